// File: doc/BRIEF.md
# Programmable Parallel Ports with Strobed Handshake

This block gives a host three parallel ports: two 8-bit data ports (A and B) and one 6-bit port (C). The host configures them by writing an 8-bit command byte and watches their condition through a 6-bit status word. Ports A and B each have a programmable direction. Each works either in basic mode, where a read samples the pins and a write drives them, or in strobed mode, where lines of port C carry an interrupt output, a buffer-full output and a strobe input for that port. Port C can be all inputs, all outputs, handshake for port A alone (its upper three pins then stay plain outputs), or handshake for both A and B.

The host interface is synchronous. A write or read is one cycle of `wr_en` or `rd_en` with a 3-bit register select. Select 0 writes the command byte and reads the status. Selects 1, 2 and 3 reach ports A, B and C. All other selects read as zero. Read data is combinational from the select. Strobes on port C are active low and are sampled on the block clock.

Each handshake channel runs one state machine. In the input direction its states are HS_IN_EMPTY, HS_IN_LOADING, HS_IN_FULL and HS_IN_FULL_IRQ. In the output direction they are HS_OUT_READY_IRQ, HS_OUT_READY, HS_OUT_FULL and HS_OUT_ACK.

- A falling strobe moves EMPTY or either FULL state to LOADING and captures the pins.
- A rising strobe moves LOADING to FULL_IRQ when the port's interrupt is enabled, and to FULL otherwise.
- A port read moves either FULL state to EMPTY.
- A port write moves READY_IRQ, READY, FULL or ACK to OUT_FULL.
- A falling strobe moves OUT_FULL to ACK.
- A rising strobe moves ACK to READY_IRQ when the interrupt is enabled, and to READY otherwise.
- When the channel is not in handshake use, or when its port changes direction, the machine re-initialises. It goes to HS_IN_EMPTY for an input port and to HS_OUT_READY_IRQ for an output port.

Top module: `pio_ports`

## Requirements
- R1: After reset every output enable is 0, every pin output is 0, the status word is 0 and both interrupt lines are low.
- R2: Command bit 0 sets the direction of port A and command bit 1 sets the direction of port B (1 = output, all eight output enables high; 0 = input, all low). The selects are 0 for command/status, 1 for A, 2 for B and 3 for C.
- R3: A port in output mode drives its latch onto its pins and reads back the latch. A write to a port in input mode is ignored, so the pins show 0 when the port later turns to output.
- R4: The output latch of port A or B is held clear while the port is an input, so each switch from input to output drives the pins low.
- R5: Command bits 3:2 select the port C mode, giving these output enables: 00 all input (6'h00), 11 all output (6'h3F), 01 A handshake (6'h3B), 10 A and B handshake (6'h1B).
- R6: In port C mode 01, PC5:3 drive bits 5:3 of the port C latch, PC0 is the A interrupt and PC1 is the A buffer-full line. In mode 10, PC3 is the B interrupt, PC4 the B buffer-full line and PC5 the B strobe. PC2 is always the A strobe in the handshake modes.
- R7: Strobed input: a low strobe captures the pins and sets buffer full. The rising strobe then sets the interrupt when it is enabled (command bit 4 for A, bit 5 for B), and the interrupt appears on irq_a/irq_b.
- R8: A read of a strobed input port returns the captured byte, even if the pins have changed since. When no new strobe falls in the same cycle, the read clears both buffer full and the interrupt.
- R9: When a port enters output handshake, buffer full is low and the interrupt is high. A port write clears the interrupt and sets buffer full. A low strobe clears buffer full, and the rising strobe sets the interrupt when it is enabled.
- R10: Status bits are 0 A interrupt, 1 A buffer full, 2 A interrupt enable, 3 B interrupt, 4 B buffer full and 5 B interrupt enable. Status bits 7:6 read as 0.
- R11: Collisions: a read that meets a falling strobe returns the old byte and leaves the port in LOADING, with buffer full set and the interrupt clear. A write that meets a falling strobe in output handshake leaves buffer full set.
- R12: A rising strobe while the port's interrupt is disabled sets no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle register write |
| rd_en | input | 1 | One-cycle register read |
| addr | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current select |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin outputs |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin outputs |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 6 | Port C pin inputs (strobes on bits 2 and 5) |
| pc_out | output | 6 | Port C pin outputs |
| pc_oe | output | 6 | Port C output enables |
| stat | output | 6 | Handshake status bits |
| irq_a | output | 1 | Port A interrupt |
| irq_b | output | 1 | Port B interrupt |

## Verification
Two pairs of events can coincide: a host read of a full input port in the same cycle as a new falling strobe, and a host write to an output port in the same cycle as a falling acknowledge strobe. The bench drives `rd_en` together with the strobe low and new pin data. It expects the read to return the old captured byte, and it expects status to show buffer full with the interrupt clear. For the output case it asserts the strobe low in the cycle of the write and expects buffer full to stay set. After that, a rising strobe alone must not advance the state, and a later full strobe must complete the acknowledge.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PC_W   = 6;
    localparam int STAT_W = 6;
    localparam int NUM_HS = 2;

    typedef enum logic [1:0] {
        PC_ALL_IN  = 2'b00,
        PC_HS_A    = 2'b01,
        PC_HS_AB   = 2'b10,
        PC_ALL_OUT = 2'b11
    } pc_mode_e;

    typedef enum logic [2:0] {
        HS_IN_EMPTY,
        HS_IN_LOADING,
        HS_IN_FULL,
        HS_IN_FULL_IRQ,
        HS_OUT_READY_IRQ,
        HS_OUT_READY,
        HS_OUT_FULL,
        HS_OUT_ACK
    } hs_state_e;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_A    = 3'd1;
    localparam logic [2:0] SEL_B    = 3'd2;
    localparam logic [2:0] SEL_C    = 3'd3;

endpackage

// File: rtl/pio_hs_fsm.sv
module pio_hs_fsm
    import pio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic dir_out,
    input  logic int_en,
    input  logic stb_n,
    input  logic port_rd,
    input  logic port_wr,
    output logic buf_full,
    output logic int_req,
    output logic cap_en
);

    hs_state_e state_q, state_d, init_s;
    logic      stb_q, dir_q;
    logic      fall, rise;

    assign fall   = stb_q & ~stb_n;
    assign rise   = ~stb_q & stb_n;
    assign init_s = dir_out ? HS_OUT_READY_IRQ : HS_IN_EMPTY;

    always_comb begin
        state_d = state_q;
        if (!active || (dir_out != dir_q)) begin
            state_d = init_s;
        end else begin
            unique case (state_q)
                HS_IN_EMPTY:
                    if (fall) state_d = HS_IN_LOADING;
                HS_IN_LOADING:
                    if (rise) state_d = int_en ? HS_IN_FULL_IRQ : HS_IN_FULL;
                HS_IN_FULL, HS_IN_FULL_IRQ:
                    if (fall)         state_d = HS_IN_LOADING;
                    else if (port_rd) state_d = HS_IN_EMPTY;
                HS_OUT_READY_IRQ, HS_OUT_READY:
                    if (port_wr) state_d = HS_OUT_FULL;
                HS_OUT_FULL:
                    if (!port_wr && fall) state_d = HS_OUT_ACK;
                HS_OUT_ACK:
                    if (port_wr)   state_d = HS_OUT_FULL;
                    else if (rise) state_d = int_en ? HS_OUT_READY_IRQ : HS_OUT_READY;
                default:
                    state_d = init_s;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IN_EMPTY;
            stb_q   <= 1'b1;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            stb_q   <= stb_n;
            dir_q   <= dir_out;
        end
    end

    always_comb begin
        buf_full = 1'b0;
        int_req  = 1'b0;
        unique case (state_q)
            HS_IN_LOADING, HS_IN_FULL, HS_OUT_FULL: buf_full = 1'b1;
            HS_IN_FULL_IRQ: begin
                buf_full = 1'b1;
                int_req  = 1'b1;
            end
            HS_OUT_READY_IRQ: int_req = 1'b1;
            default: ;
        endcase
        buf_full = buf_full & active;
        int_req  = int_req & active;
        cap_en   = active & ~dir_out & (state_d == HS_IN_LOADING)
                   & (state_q != HS_IN_LOADING);
    end

endmodule

// File: rtl/pio_data_port.sv
module pio_data_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_out,
    input  logic         strobed,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pins_in,
    input  logic         cap_en,
    output logic [W-1:0] pins_out,
    output logic [W-1:0] pins_oe,
    output logic [W-1:0] rd_val
);

    logic [W-1:0] out_lat, in_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_lat <= '0;
            in_lat  <= '0;
        end else begin
            if (!dir_out)  out_lat <= '0;
            else if (wr)   out_lat <= wdata;
            if (cap_en)    in_lat  <= pins_in;
        end
    end

    assign pins_out = out_lat;
    assign pins_oe  = {W{dir_out}};

    always_comb begin
        if (dir_out)      rd_val = out_lat;
        else if (strobed) rd_val = in_lat;
        else              rd_val = pins_in;
    end

endmodule

// File: rtl/pio_port_c.sv
module pio_port_c
    import pio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  pc_mode_e        mode,
    input  logic            wr,
    input  logic [PC_W-1:0] wdata,
    input  logic [PC_W-1:0] pins_in,
    input  logic [1:0]      hs_int,
    input  logic [1:0]      hs_full,
    output logic [PC_W-1:0] pins_out,
    output logic [PC_W-1:0] pins_oe,
    output logic [PC_W-1:0] rd_val
);

    logic [PC_W-1:0] lat;

    always_ff @(posedge clk) begin
        if (rst)                    lat <= '0;
        else if (mode == PC_ALL_IN) lat <= '0;
        else if (wr)                lat <= wdata;
    end

    always_comb begin
        unique case (mode)
            PC_ALL_IN: begin
                pins_oe  = 6'h00;
                pins_out = lat;
            end
            PC_ALL_OUT: begin
                pins_oe  = 6'h3F;
                pins_out = lat;
            end
            PC_HS_A: begin
                pins_oe  = 6'h3B;
                pins_out = {lat[5:3], 1'b0, hs_full[0], hs_int[0]};
            end
            PC_HS_AB: begin
                pins_oe  = 6'h1B;
                pins_out = {1'b0, hs_full[1], hs_int[1], 1'b0, hs_full[0], hs_int[0]};
            end
            default: begin
                pins_oe  = 6'h00;
                pins_out = lat;
            end
        endcase
        rd_val = (pins_out & pins_oe) | (pins_in & ~pins_oe);
    end

endmodule

// File: rtl/pio_ports.sv
module pio_ports
    import pio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic [PC_W-1:0]   pc_in,
    output logic [PC_W-1:0]   pc_out,
    output logic [PC_W-1:0]   pc_oe,
    output logic [STAT_W-1:0] stat,
    output logic              irq_a,
    output logic              irq_b
);

    localparam int PAD_W = DATA_W - STAT_W;

    logic [DATA_W-1:0] cmd_q;
    pc_mode_e          pc_mode;
    logic [NUM_HS-1:0] hs_active, hs_dir, hs_ie, hs_stb, hs_rd, hs_wr;
    logic [NUM_HS-1:0] hs_full, hs_int, hs_cap;
    logic [NUM_HS-1:0][DATA_W-1:0] p_in, p_out, p_oe, p_rd;
    logic [PC_W-1:0]   pc_rd;

    always_ff @(posedge clk) begin
        if (rst)                                            cmd_q <= '0;
        else if (wr_en && (addr == ADDR_W'(SEL_CTRL)))      cmd_q <= wdata;
    end

    assign pc_mode      = pc_mode_e'(cmd_q[3:2]);
    assign hs_active[0] = (pc_mode == PC_HS_A) || (pc_mode == PC_HS_AB);
    assign hs_active[1] = (pc_mode == PC_HS_AB);
    assign hs_dir       = cmd_q[1:0];
    assign hs_ie        = cmd_q[5:4];
    assign hs_stb       = {pc_in[5], pc_in[2]};
    assign p_in         = {pb_in, pa_in};

    for (genvar i = 0; i < NUM_HS; i++) begin : g_port
        assign hs_rd[i] = rd_en && (addr == ADDR_W'(SEL_A + i));
        assign hs_wr[i] = wr_en && (addr == ADDR_W'(SEL_A + i));

        pio_hs_fsm u_fsm (
            .clk      (clk),
            .rst      (rst),
            .active   (hs_active[i]),
            .dir_out  (hs_dir[i]),
            .int_en   (hs_ie[i]),
            .stb_n    (hs_stb[i]),
            .port_rd  (hs_rd[i]),
            .port_wr  (hs_wr[i]),
            .buf_full (hs_full[i]),
            .int_req  (hs_int[i]),
            .cap_en   (hs_cap[i])
        );

        pio_data_port #(.W(DATA_W)) u_port (
            .clk      (clk),
            .rst      (rst),
            .dir_out  (hs_dir[i]),
            .strobed  (hs_active[i]),
            .wr       (hs_wr[i]),
            .wdata    (wdata),
            .pins_in  (p_in[i]),
            .cap_en   (hs_cap[i]),
            .pins_out (p_out[i]),
            .pins_oe  (p_oe[i]),
            .rd_val   (p_rd[i])
        );
    end

    pio_port_c u_pc (
        .clk      (clk),
        .rst      (rst),
        .mode     (pc_mode),
        .wr       (wr_en && (addr == ADDR_W'(SEL_C))),
        .wdata    (wdata[PC_W-1:0]),
        .pins_in  (pc_in),
        .hs_int   (hs_int),
        .hs_full  (hs_full),
        .pins_out (pc_out),
        .pins_oe  (pc_oe),
        .rd_val   (pc_rd)
    );

    assign pa_out = p_out[0];
    assign pa_oe  = p_oe[0];
    assign pb_out = p_out[1];
    assign pb_oe  = p_oe[1];
    assign stat   = {hs_ie[1], hs_full[1], hs_int[1], hs_ie[0], hs_full[0], hs_int[0]};
    assign irq_a  = hs_int[0];
    assign irq_b  = hs_int[1];

    always_comb begin
        unique case (addr)
            ADDR_W'(SEL_CTRL): rdata = {{PAD_W{1'b0}}, stat};
            ADDR_W'(SEL_A):    rdata = p_rd[0];
            ADDR_W'(SEL_B):    rdata = p_rd[1];
            ADDR_W'(SEL_C):    rdata = {{(DATA_W-PC_W){1'b0}}, pc_rd};
            default:           rdata = '0;
        endcase
    end

endmodule

// File: rtl/pio_ports_chk.sv
module pio_ports_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] pa_out,
    input logic [DATA_W-1:0] pa_oe,
    input logic [5:0]        pc_in,
    input logic [5:0]        pc_oe,
    input logic [5:0]        stat,
    input logic [DATA_W-1:0] cmd_q
);

    logic stb_a_seen;
    logic a_hs;

    always_ff @(posedge clk) begin
        if (rst) stb_a_seen <= 1'b1;
        else     stb_a_seen <= pc_in[2];
    end

    assign a_hs = (cmd_q[3:2] == 2'b01) || (cmd_q[3:2] == 2'b10);

    // R2
    dir_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == '0) || (pa_oe == '1));

    // R4
    latch_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        !pa_oe[0] |=> (pa_oe[0] || (pa_out == '0)));

    // R4
    enter_output_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pa_oe[0]) |-> (pa_out == '0));

    // R5
    pc_oe_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_oe == 6'h00) || (pc_oe == 6'h3F) || (pc_oe == 6'h3B) || (pc_oe == 6'h1B));

    // R9
    out_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == ADDR_W'(1)) && cmd_q[0] && a_hs && $stable(cmd_q[0]))
        |=> (stat[1] && !stat[0]));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && (addr == ADDR_W'(1)) && !cmd_q[0] && a_hs
         && $stable(cmd_q[0]) && pc_in[2] && stb_a_seen)
        |=> (!stat[1] && !stat[0]));

endmodule

bind pio_ports pio_ports_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .pa_out (pa_out),
    .pa_oe  (pa_oe),
    .pc_in  (pc_in),
    .pc_oe  (pc_oe),
    .stat   (stat),
    .cmd_q  (cmd_q)
);

// File: tb/pio_ports_tb.sv
`timescale 1ns/1ps
module pio_ports_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] pa_in = '0, pa_out, pa_oe;
    logic [7:0] pb_in = '0, pb_out, pb_oe;
    logic [5:0] pc_in = 6'h3F, pc_out, pc_oe, stat;
    logic       irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    pio_ports u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .stat(stat), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, logic [7:0] exp, string req);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: compares read data against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_en) begin
                if (exp_q.size() == 0) begin
                    chk("unexpected read", rdata, 8'hxx);
                end else begin
                    chk(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pc_oe", {2'b0, pc_oe}, 8'h00);
        chk("R1 stat", {2'b0, stat}, 8'h00);
        chk("R1 irq", {6'b0, irq_b, irq_a}, 8'h00);
        rd(3'd0, 8'h00, "R1 status read");

        // R3 write in input mode ignored, then output drive and readback
        wr(3'd1, 8'hA5);
        wr(3'd0, 8'h01);
        chk("R2 pa_oe out", pa_oe, 8'hFF);
        chk("R3 ignored write", pa_out, 8'h00);
        wr(3'd1, 8'h3C);
        chk("R3 pa_out", pa_out, 8'h3C);
        rd(3'd1, 8'h3C, "R3 readback");

        // R4 input then output again drives low
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h01);
        chk("R4 pins low", pa_out, 8'h00);

        // R2 port B direction
        wr(3'd0, 8'h02);
        chk("R2 pb_oe", pb_oe, 8'hFF);
        chk("R2 pa_oe in", pa_oe, 8'h00);

        // R5 / R6 port C modes
        wr(3'd0, 8'h0C);
        chk("R5 mode 11", {2'b0, pc_oe}, 8'h3F);
        wr(3'd3, 8'h2A);
        chk("R5 pc_out", {2'b0, pc_out}, 8'h2A);
        rd(3'd3, 8'h2A, "R5 pc readback");
        wr(3'd0, 8'h04);
        chk("R5 mode 01", {2'b0, pc_oe}, 8'h3B);
        chk("R6 mode 01 pins", {2'b0, pc_out & pc_oe}, 8'h28);
        wr(3'd0, 8'h08);
        chk("R5 mode 10", {2'b0, pc_oe}, 8'h1B);

        // R7 / R8 / R10 strobed input on A with interrupt enabled
        wr(3'd0, 8'h14);
        tick(1);
        chk("R10 ie A", {2'b0, stat}, 8'h04);
        pa_in = 8'h5A; pc_in[2] = 1'b0;
        tick(1);
        chk("R7 bf set", {2'b0, stat}, 8'h06);
        chk("R6 PC1 bf", {7'b0, pc_out[1]}, 8'h01);
        pa_in = 8'h11; pc_in[2] = 1'b1;
        tick(1);
        chk("R7 intr set", {2'b0, stat}, 8'h07);
        chk("R7 irq_a", {7'b0, irq_a}, 8'h01);
        rd(3'd0, 8'h07, "R10 status read");
        rd(3'd1, 8'h5A, "R8 captured data");
        chk("R8 cleared", {2'b0, stat}, 8'h04);

        // R12 no interrupt when disabled
        wr(3'd0, 8'h04);
        pa_in = 8'h22; pc_in[2] = 1'b0;
        tick(1);
        pc_in[2] = 1'b1;
        tick(1);
        chk("R12 no intr", {2'b0, stat}, 8'h02);
        rd(3'd1, 8'h22, "R12 data");
        chk("R12 cleared", {2'b0, stat}, 8'h00);

        // R11 read meets falling strobe
        wr(3'd0, 8'h14);
        pa_in = 8'h33; pc_in[2] = 1'b0;
        tick(1);
        pc_in[2] = 1'b1;
        tick(1);
        chk("R11 pre full", {2'b0, stat}, 8'h07);
        pa_in = 8'h44; pc_in[2] = 1'b0;
        rd(3'd1, 8'h33, "R11 old data");
        chk("R11 loading", {2'b0, stat}, 8'h06);
        pc_in[2] = 1'b1;
        tick(1);
        chk("R11 new full", {2'b0, stat}, 8'h07);
        rd(3'd1, 8'h44, "R11 new data");
        chk("R8 empty", {2'b0, stat}, 8'h04);

        // R9 strobed output on A
        wr(3'd0, 8'h15);
        tick(1);
        chk("R9 entry", {2'b0, stat}, 8'h05);
        chk("R4 entry low", pa_out, 8'h00);
        wr(3'd1, 8'h77);
        chk("R9 after write", {2'b0, stat}, 8'h06);
        chk("R9 pa_out", pa_out, 8'h77);
        pc_in[2] = 1'b0;
        tick(1);
        chk("R9 ack bf low", {2'b0, stat}, 8'h04);
        pc_in[2] = 1'b1;
        tick(1);
        chk("R9 intr set", {2'b0, stat}, 8'h05);
        chk("R9 irq_a", {7'b0, irq_a}, 8'h01);

        // R11 write meets falling strobe
        pc_in[2] = 1'b0;
        wr(3'd1, 8'h88);
        chk("R11 write wins", {2'b0, stat}, 8'h06);
        pc_in[2] = 1'b1;
        tick(1);
        chk("R11 rise alone", {2'b0, stat}, 8'h06);
        pc_in[2] = 1'b0;
        tick(1);
        pc_in[2] = 1'b1;
        tick(1);
        chk("R11 ack done", {2'b0, stat}, 8'h05);

        // R7 / R6 strobed input on B in mode 10
        wr(3'd0, 8'h28);
        tick(1);
        chk("R10 ie B", {2'b0, stat}, 8'h20);
        pb_in = 8'hC3; pc_in[5] = 1'b0;
        tick(1);
        chk("R7 B bf", {2'b0, stat}, 8'h30);
        chk("R6 PC4 bf", {7'b0, pc_out[4]}, 8'h01);
        pb_in = 8'h00; pc_in[5] = 1'b1;
        tick(1);
        chk("R7 B intr", {2'b0, stat}, 8'h38);
        chk("R6 PC3 intr", {7'b0, pc_out[3]}, 8'h01);
        chk("R7 irq_b", {7'b0, irq_b}, 8'h01);
        rd(3'd2, 8'hC3, "R8 B data");
        chk("R8 B cleared", {2'b0, stat}, 8'h20);

        tick(2);
        if (exp_q.size() != 0) chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule